// File: doc/BRIEF.md
# Two-Stage Return-Stack Action Reconciler

This block sits between the branch prediction pipeline and a return address stack. In prediction stage 2 it looks at the fetch block's call and return flags, works out the return address of a call, and issues a speculative push or pop to the stack in the same cycle. The stage-2 decision and the top-of-stack value read in stage 2 are registered alongside the block into stage 3.

In stage 3 the block classifies the same fetch block again using the later, more complete information. It compares that result with the registered stage-2 decision. When they differ, it emits one compensating push or pop, taken from a fixed table of action pairs. It never rolls the stack back in full. The stage-3 target always comes from the top-of-stack captured in stage 2. A backend redirect is held for one clock and then forwarded to the stack. The stack storage itself lives outside this block.

Top module: `ras_act_reconciler`

## Requirements
- R1: When `s2_valid_i` is 1 and `s2_call_i` is 1, `s2_push_o` is 1 in the same cycle and `s2_push_addr_o` equals `s2_fall_i`.
- R2: When the truncated-call flag of a stage is 1, the return address of that stage is its fall-through address plus 2. Otherwise it is the fall-through address unchanged.
- R3: A valid block with `call`=0 and `ret`=1 gives a pop. A block with both flags set gives only a push. Push and pop are never both 1 in a stage.
- R4: When `s2_valid_i` is 0, `s2_push_o` and `s2_pop_o` are 0. A later stage 3 then treats that block as having had no stage-2 action.
- R5: No fix is issued in the following cases:
  - both stages push;
  - both stages pop;
  - neither stage acts;
  - the pair is one of the two pairs the table leaves out (stage-2 push with stage-3 pop, and stage-2 pop with stage-3 push).
- R6: A stage-2 push followed by no stage-3 action gives `s3_fix_pop_o`=1.
- R7: A stage-2 pop followed by no stage-3 action gives `s3_fix_push_o`=1, with `s3_fix_addr_o` equal to the top-of-stack captured in stage 2.
- R8: No stage-2 action followed by a stage-3 push gives `s3_fix_push_o`=1, with `s3_fix_addr_o` equal to the stage-3 return address.
- R9: No stage-2 action followed by a stage-3 pop gives `s3_fix_pop_o`=1.
- R10: `s3_target_o` equals the `s2_tos_i` value sampled at the previous rising edge, whether or not a fix is issued.
- R11: When `s3_valid_i` is 0 or `s3_flush_i` is 1, both fix outputs are 0.
- R12: `redir_valid_o` and `redir_meta_o` repeat `redir_valid_i` and `redir_meta_i` exactly one clock later.
- R13: Reset (active-low `rst_n`) clears the following: the registered stage-2 decision (to no action), the registered top-of-stack (to 0), and the redirect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s2_valid_i | input | 1 | Stage-2 block valid |
| s2_call_i | input | 1 | Stage-2 block ends in a taken call |
| s2_ret_i | input | 1 | Stage-2 block ends in a taken return |
| s2_fall_i | input | ADDR_W | Stage-2 fall-through address |
| s2_trunc_i | input | 1 | Stage-2 last call is a truncated 4-byte instruction |
| s2_tos_i | input | ADDR_W | Top-of-stack read in stage 2 |
| s3_valid_i | input | 1 | Stage-3 block valid |
| s3_flush_i | input | 1 | Stage-3 block is flushed |
| s3_call_i | input | 1 | Stage-3 block ends in a taken call |
| s3_ret_i | input | 1 | Stage-3 block ends in a taken return |
| s3_fall_i | input | ADDR_W | Stage-3 fall-through address |
| s3_trunc_i | input | 1 | Stage-3 last call is truncated |
| redir_valid_i | input | 1 | Backend redirect strobe |
| redir_meta_i | input | META_W | Recovery metadata with the redirect |
| s2_push_o | output | 1 | Stage-2 speculative push |
| s2_pop_o | output | 1 | Stage-2 speculative pop |
| s2_push_addr_o | output | ADDR_W | Stage-2 push address |
| s3_fix_push_o | output | 1 | Stage-3 corrective push |
| s3_fix_pop_o | output | 1 | Stage-3 corrective pop |
| s3_fix_addr_o | output | ADDR_W | Address for the corrective push |
| s3_target_o | output | ADDR_W | Stage-3 predicted return target |
| redir_valid_o | output | 1 | Delayed redirect strobe |
| redir_meta_o | output | META_W | Delayed redirect metadata |

## Verification
The stage-2 push, pop and push address are combinational, so the bench samples them one nanosecond after it drives inputs on the falling edge. The fix outputs and the stage-3 target depend on state captured at the rising edge between stage 2 and stage 3. For these, the bench drives stage 3 on the following falling edge and samples just after, so each pair is checked exactly one cycle after its stage-2 stimulus. The redirect is checked on both sides of its one-cycle delay: it must still be absent in the cycle it is driven, present in the next cycle, and gone in the cycle after.

// File: rtl/ras_rec_pkg.sv
package ras_rec_pkg;
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_PUSH = 2'd1,
      ACT_POP  = 2'd2
   } ras_act_e;

   typedef struct packed {
      logic fix_push;
      logic fix_pop;
      logic from_s3;   // corrective push takes the stage-3 return address
   } ras_fix_t;
endpackage

// File: rtl/ras_rec_classify.sv
module ras_rec_classify
   import ras_rec_pkg::*;
#(
   parameter int ADDR_W    = 40,
   parameter int HALF_STEP = 2
) (
   input  logic              valid_i,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic [ADDR_W-1:0] fall_i,
   input  logic              trunc_i,
   output ras_act_e          act_o,
   output logic [ADDR_W-1:0] ret_addr_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(HALF_STEP);

   always_comb begin
      act_o = ACT_NONE;
      if (valid_i) begin
         if (call_i)     act_o = ACT_PUSH;
         else if (ret_i) act_o = ACT_POP;
      end
   end

   assign ret_addr_o = trunc_i ? (fall_i + STEP) : fall_i;
endmodule

// File: rtl/ras_rec_fixtab.sv
module ras_rec_fixtab
   import ras_rec_pkg::*;
(
   input  logic     en_i,
   input  ras_act_e s2_act_i,
   input  ras_act_e s3_act_i,
   output ras_rec_pkg::ras_fix_t fix_o
);
   always_comb begin
      fix_o = '0;
      if (en_i) begin
         unique case ({s2_act_i, s3_act_i})
            {ACT_PUSH, ACT_NONE}: fix_o.fix_pop  = 1'b1;
            {ACT_POP,  ACT_NONE}: fix_o.fix_push = 1'b1;
            {ACT_NONE, ACT_PUSH}: begin
               fix_o.fix_push = 1'b1;
               fix_o.from_s3  = 1'b1;
            end
            {ACT_NONE, ACT_POP }: fix_o.fix_pop  = 1'b1;
            default:              fix_o        = '0;
         endcase
      end
   end
endmodule

// File: rtl/ras_rec_delay.sv
module ras_rec_delay #(
   parameter int W     = 16,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_i,
   input  logic [W-1:0] dat_i,
   output logic         vld_o,
   output logic [W-1:0] dat_o
);
   generate
      if (DEPTH == 0) begin : g_pass
         assign vld_o = vld_i;
         assign dat_o = dat_i;
      end else begin : g_pipe
         logic [DEPTH-1:0]        vld_q;
         logic [DEPTH-1:0][W-1:0] dat_q;
         for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  vld_q[i] <= 1'b0;
                  dat_q[i] <= '0;
               end else begin
                  vld_q[i] <= (i == 0) ? vld_i : vld_q[(i == 0) ? 0 : i-1];
                  dat_q[i] <= (i == 0) ? dat_i : dat_q[(i == 0) ? 0 : i-1];
               end
            end
         end
         assign vld_o = vld_q[DEPTH-1];
         assign dat_o = dat_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/ras_act_reconciler.sv
module ras_act_reconciler
   import ras_rec_pkg::*;
#(
   parameter int ADDR_W      = 40,
   parameter int META_W      = 16,
   parameter int HALF_STEP   = 2,
   parameter int REDIR_DELAY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s2_valid_i,
   input  logic              s2_call_i,
   input  logic              s2_ret_i,
   input  logic [ADDR_W-1:0] s2_fall_i,
   input  logic              s2_trunc_i,
   input  logic [ADDR_W-1:0] s2_tos_i,
   input  logic              s3_valid_i,
   input  logic              s3_flush_i,
   input  logic              s3_call_i,
   input  logic              s3_ret_i,
   input  logic [ADDR_W-1:0] s3_fall_i,
   input  logic              s3_trunc_i,
   input  logic              redir_valid_i,
   input  logic [META_W-1:0] redir_meta_i,
   output logic              s2_push_o,
   output logic              s2_pop_o,
   output logic [ADDR_W-1:0] s2_push_addr_o,
   output logic              s3_fix_push_o,
   output logic              s3_fix_pop_o,
   output logic [ADDR_W-1:0] s3_fix_addr_o,
   output logic [ADDR_W-1:0] s3_target_o,
   output logic              redir_valid_o,
   output logic [META_W-1:0] redir_meta_o
);
   if (ADDR_W < 8)      begin : g_bad_addr  $error("ADDR_W too small");     end
   if (META_W < 1)      begin : g_bad_meta  $error("META_W must be >= 1");  end
   if (HALF_STEP != 2 && HALF_STEP != 4) begin : g_bad_step $error("HALF_STEP must be 2 or 4"); end
   if (REDIR_DELAY < 1) begin : g_bad_delay $error("REDIR_DELAY must be >= 1"); end

   ras_act_e          s2_act, s3_act, s2_act_q;
   logic [ADDR_W-1:0] s2_ret_addr, s3_ret_addr, tos_q;
   ras_fix_t          fix;
   logic              s3_live;

   ras_rec_classify #(.ADDR_W(ADDR_W), .HALF_STEP(HALF_STEP)) u_cls_s2 (
      .valid_i(s2_valid_i), .call_i(s2_call_i), .ret_i(s2_ret_i),
      .fall_i(s2_fall_i), .trunc_i(s2_trunc_i),
      .act_o(s2_act), .ret_addr_o(s2_ret_addr)
   );

   ras_rec_classify #(.ADDR_W(ADDR_W), .HALF_STEP(HALF_STEP)) u_cls_s3 (
      .valid_i(s3_valid_i), .call_i(s3_call_i), .ret_i(s3_ret_i),
      .fall_i(s3_fall_i), .trunc_i(s3_trunc_i),
      .act_o(s3_act), .ret_addr_o(s3_ret_addr)
   );

   assign s2_push_o      = (s2_act == ACT_PUSH);
   assign s2_pop_o       = (s2_act == ACT_POP);
   assign s2_push_addr_o = s2_ret_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_act_q <= ACT_NONE;
         tos_q    <= '0;
      end else begin
         s2_act_q <= s2_act;
         tos_q    <= s2_tos_i;
      end
   end

   assign s3_live = s3_valid_i && !s3_flush_i;

   ras_rec_fixtab u_fixtab (
      .en_i(s3_live), .s2_act_i(s2_act_q), .s3_act_i(s3_act), .fix_o(fix)
   );

   assign s3_fix_push_o = fix.fix_push;
   assign s3_fix_pop_o  = fix.fix_pop;
   assign s3_fix_addr_o = fix.from_s3 ? s3_ret_addr : tos_q;
   assign s3_target_o   = tos_q;

   ras_rec_delay #(.W(META_W), .DEPTH(REDIR_DELAY)) u_redir (
      .clk(clk), .rst_n(rst_n),
      .vld_i(redir_valid_i), .dat_i(redir_meta_i),
      .vld_o(redir_valid_o), .dat_o(redir_meta_o)
   );

   a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      !(s2_push_o && s2_pop_o));
   a_r4_idle_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      !s2_valid_i |-> !(s2_push_o || s2_pop_o));
   a_r11_no_fix_dead: assert property (@(posedge clk) disable iff (!rst_n)
      !s3_live |-> !(s3_fix_push_o || s3_fix_pop_o));
   a_r5_single_fix: assert property (@(posedge clk) disable iff (!rst_n)
      !(s3_fix_push_o && s3_fix_pop_o));
   a_r10_target_from_s2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (s3_target_o == $past(s2_tos_i)));
   a_r6_undo_push: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(s2_push_o) && s3_live && !s3_call_i && !s3_ret_i) |-> s3_fix_pop_o);
   a_r12_redir_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (REDIR_DELAY == 1 && $past(rst_n)) |-> (redir_valid_o == $past(redir_valid_i)));
endmodule

// File: tb/ras_act_reconciler_bench.sv
module ras_act_reconciler_bench;
   localparam int AW = 40;
   localparam int MW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic s2_valid_i = 0, s2_call_i = 0, s2_ret_i = 0, s2_trunc_i = 0;
   logic [AW-1:0] s2_fall_i = '0, s2_tos_i = '0;
   logic s3_valid_i = 0, s3_flush_i = 0, s3_call_i = 0, s3_ret_i = 0, s3_trunc_i = 0;
   logic [AW-1:0] s3_fall_i = '0;
   logic redir_valid_i = 0;
   logic [MW-1:0] redir_meta_i = '0;
   logic s2_push_o, s2_pop_o, s3_fix_push_o, s3_fix_pop_o, redir_valid_o;
   logic [AW-1:0] s2_push_addr_o, s3_fix_addr_o, s3_target_o;
   logic [MW-1:0] redir_meta_o;

   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   ras_act_reconciler u_ras_act_reconciler (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // act codes: 0 none, 1 push (call), 2 pop (return), 3 both flags
   task automatic drive_s2(input int a, input logic v, input logic [AW-1:0] fall,
                           input logic tr, input logic [AW-1:0] tos);
      s2_valid_i = v; s2_call_i = (a == 1 || a == 3); s2_ret_i = (a == 2 || a == 3);
      s2_fall_i = fall; s2_trunc_i = tr; s2_tos_i = tos;
   endtask

   task automatic drive_s3(input int a, input logic v, input logic fl,
                           input logic [AW-1:0] fall, input logic tr);
      s3_valid_i = v; s3_flush_i = fl; s3_call_i = (a == 1); s3_ret_i = (a == 2);
      s3_fall_i = fall; s3_trunc_i = tr;
   endtask

   // Run one block through stage 2 then stage 3 and check the fix.
   task automatic run_pair(input string req, input int a2, input logic v2, input int a3,
                           input logic v3, input logic fl, input logic tr3,
                           input logic [AW-1:0] tos);
      logic [AW-1:0] f3;
      logic ep, eo;
      int e2;
      f3 = 40'h80_0000_1000 + tos[11:0];
      @(negedge clk);
      drive_s2(a2, v2, 40'h10_0000_0100, 1'b0, tos);
      drive_s3(0, 1'b0, 1'b0, '0, 1'b0);
      @(negedge clk);
      drive_s2(0, 1'b0, '0, 1'b0, 40'h5A5A);
      drive_s3(a3, v3, fl, f3, tr3);
      #1;
      e2 = !v2 ? 0 : a2;
      ep = 0; eo = 0;
      if (v3 && !fl) begin
         if (e2 == 1 && a3 == 0) eo = 1;
         if (e2 == 2 && a3 == 0) ep = 1;
         if (e2 == 0 && a3 == 1) ep = 1;
         if (e2 == 0 && a3 == 2) eo = 1;
      end
      check({req, " fix_push"}, 64'(s3_fix_push_o), 64'(ep));
      check({req, " fix_pop"},  64'(s3_fix_pop_o),  64'(eo));
      check({"R10 target"}, 64'(s3_target_o), 64'(tos));
      if (ep)
         check({req, " fix_addr"}, 64'(s3_fix_addr_o),
               64'((e2 == 0) ? (tr3 ? f3 + 40'd2 : f3) : tos));
   endtask

   task automatic test_s2_class();
      @(negedge clk);
      drive_s2(1, 1'b1, 40'h12_3456_7000, 1'b0, '0); #1;
      check("R1 push", 64'(s2_push_o), 64'd1);
      check("R1 push_addr", 64'(s2_push_addr_o), 64'h12_3456_7000);
      drive_s2(1, 1'b1, 40'h12_3456_7000, 1'b1, '0); #1;
      check("R2 trunc addr", 64'(s2_push_addr_o), 64'h12_3456_7002);
      drive_s2(2, 1'b1, 40'h1000, 1'b0, '0); #1;
      check("R3 pop", 64'(s2_pop_o), 64'd1);
      check("R3 no push on ret", 64'(s2_push_o), 64'd0);
      drive_s2(3, 1'b1, 40'h1000, 1'b0, '0); #1;
      check("R3 both flags push", 64'(s2_push_o), 64'd1);
      check("R3 both flags no pop", 64'(s2_pop_o), 64'd0);
      drive_s2(1, 1'b0, 40'h1000, 1'b0, '0); #1;
      check("R4 invalid push", 64'(s2_push_o), 64'd0);
      drive_s2(2, 1'b0, 40'h1000, 1'b0, '0); #1;
      check("R4 invalid pop", 64'(s2_pop_o), 64'd0);
      drive_s2(0, 1'b0, '0, 1'b0, '0);
   endtask

   task automatic test_redirect();
      @(negedge clk);
      redir_valid_i = 1; redir_meta_i = 16'hBEEF; #1;
      check("R12 not yet", 64'(redir_valid_o), 64'd0);
      @(negedge clk);
      redir_valid_i = 0; redir_meta_i = 16'h0; #1;
      check("R12 valid", 64'(redir_valid_o), 64'd1);
      check("R12 meta", 64'(redir_meta_o), 64'hBEEF);
      @(negedge clk); #1;
      check("R12 gone", 64'(redir_valid_o), 64'd0);
   endtask

   initial begin
      drive_s3(0, 1'b1, 1'b0, '0, 1'b0);
      s2_tos_i = 40'h77;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      check("R13 target reset", 64'(s3_target_o), 64'd0);
      check("R13 no fix", 64'(s3_fix_push_o | s3_fix_pop_o), 64'd0);
      check("R13 redir", 64'(redir_valid_o), 64'd0);
      s2_tos_i = '0;
      rst_n = 1'b1;

      test_s2_class();
      run_pair("R5 push/push", 1, 1, 1, 1, 0, 0, 40'h111);
      run_pair("R5 pop/pop",   2, 1, 2, 1, 0, 0, 40'h222);
      run_pair("R5 none/none", 0, 1, 0, 1, 0, 0, 40'h333);
      run_pair("R5 push/pop",  1, 1, 2, 1, 0, 0, 40'h344);
      run_pair("R5 pop/push",  2, 1, 1, 1, 0, 0, 40'h355);
      run_pair("R6 push/none", 1, 1, 0, 1, 0, 0, 40'h444);
      run_pair("R7 pop/none",  2, 1, 0, 1, 0, 0, 40'h5555);
      run_pair("R8 none/push", 0, 1, 1, 1, 0, 0, 40'h666);
      run_pair("R8 trunc",     0, 1, 1, 1, 0, 1, 40'h677);
      run_pair("R9 none/pop",  0, 1, 2, 1, 0, 0, 40'h777);
      run_pair("R4 inv s2 then push", 1, 0, 1, 1, 0, 0, 40'h888);
      run_pair("R11 invalid s3", 1, 1, 0, 0, 0, 0, 40'h999);
      run_pair("R11 flushed s3", 0, 1, 2, 1, 1, 0, 40'haaa);
      test_redirect();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule